// File: doc/BRIEF.md
# Write-Once Boot Configuration Word

This block holds a 32-bit configuration word that can be programmed once and is kept through power loss. Software stages a new value with register writes. A staged write may only clear bits. It must also leave the reserved bit ranges at 1. A write that breaks either rule is rejected as a whole and raises a sticky error flag.

A commit strobe copies the staged value into nonvolatile storage and clears the lock bit in the stored copy. The word can therefore be committed only once. The active value, which is what reads return and what drives the decoded outputs, is loaded from storage only at power-on reset. A commit therefore stays invisible until the next power cycle. A system reset discards staged changes and clears the error flag, but it leaves both the active and the stored word alone.

Two fields are decoded from the active word:
- Debug enable is on only for the pattern 1 in bit 1 with 0 in bit 0.
- Bit 4 selects the flash write key. When it is 1, a fixed built-in key is used. When it is 0, a user-supplied key is used and the fixed key is refused.

Each presented key produces a one-cycle accept or reject pulse.

Top module: `cfgword_otp`

## Requirements
- R1: While por_n is low at a clock edge and nothing has been committed, the active word is loaded with 0xFFFFFFFE. After por_n is released, rd_data reads 0xFFFFFFFE and commit_err reads 0.
- R2: A staged write is accepted only if it sets no bit that is 0 in the staged value and keeps bits 30:16, 7:5 and 3:2 at 1. Otherwise the staged value is unchanged and commit_err goes to 1 in the cycle after the write and stays there.
- R3: A commit stores the staged value with bit 31 cleared. rd_data keeps the previous active value until the next power-on reset, after which it reads the stored value.
- R4: A sys_rst_n pulse leaves rd_data and the stored word unchanged. It restores the staged value to the active word and clears commit_err.
- R5: When bit 31 of the stored word is 0, a commit has no effect. A later power-on reset still shows the first committed value.
- R6: dbg_en is 1 exactly when bit 1 of the active word is 1 and bit 0 is 0.
- R7: When bit 4 of the active word is 1, a key presented with key_valid produces key_ok in the next cycle if it equals 0xA442, and key_bad otherwise. Each pulse lasts one cycle.
- R8: When bit 4 of the active word is 0, a key is accepted only if it equals user_key and differs from 0xA442. Every other key gives key_bad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, sampled on the clock |
| sys_rst_n | input | 1 | System reset, active low, sampled on the clock |
| wr_en | input | 1 | Stage-write strobe |
| wr_data | input | 32 | Value to stage |
| commit | input | 1 | Commit strobe: copy staged value to storage |
| rd_data | output | 32 | Active configuration word |
| commit_err | output | 1 | Sticky flag for a rejected staged write |
| dbg_en | output | 1 | Debug access permitted |
| fixed_key_sel | output | 1 | Active bit 4: fixed key in use |
| key_valid | input | 1 | A key is presented this cycle |
| key_in | input | 16 | Presented flash write key |
| user_key | input | 16 | User-committed key value |
| key_ok | output | 1 | One-cycle accept pulse |
| key_bad | output | 1 | One-cycle reject pulse |

## Verification
The key checker is driven from a table of keys: the fixed key, near misses one bit away, all zeros, and the user key. Running the table under both settings of bit 4 shows whether the selection really switches between the two keys, and whether the fixed key is refused in user mode even when it equals user_key. The staging path is tried with a write that clears a reserved bit, a write that sets a cleared bit, and a legal clearing write. Each result is made visible through a commit followed by a power cycle, which separates a rejected write from an accepted one. Commit before power cycle, system reset after commit, and a second commit after locking each test one part of the timing of when the value becomes visible and stays.

// File: rtl/cfgword_otp.sv
module cfgword_otp #(
  parameter int W = 32,
  parameter int KW = 16,
  parameter logic [W-1:0] FACTORY = 32'hFFFF_FFFE,
  parameter logic [W-1:0] RSV_MASK = 32'h7FFF_00EC,
  parameter logic [KW-1:0] FIXED_KEY = 16'hA442,
  parameter int LOCK_BIT = 31,
  parameter int DBG_ON_BIT = 1,
  parameter int DBG_OFF_BIT = 0,
  parameter int KEYSEL_BIT = 4
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          sys_rst_n,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          commit,
  output logic [W-1:0]  rd_data,
  output logic          commit_err,
  output logic          dbg_en,
  output logic          fixed_key_sel,
  input  logic          key_valid,
  input  logic [KW-1:0] key_in,
  input  logic [KW-1:0] user_key,
  output logic          key_ok,
  output logic          key_bad
);
  localparam logic [W-1:0] LOCK_M = {{(W-1){1'b0}}, 1'b1} << LOCK_BIT;

  logic [W-1:0] nv_q = FACTORY;
  logic [W-1:0] act_q, clr_q, stage;
  logic         err_q, ok_q, bad_q, run, wr_ok, match;

  assign run   = por_n && sys_rst_n;
  assign stage = act_q & ~clr_q;
  assign wr_ok = ((wr_data & ~stage) == '0) && ((wr_data & RSV_MASK) == RSV_MASK);
  assign match = act_q[KEYSEL_BIT] ? (key_in == FIXED_KEY)
                                   : (key_in == user_key && key_in != FIXED_KEY);

  always_ff @(posedge clk)
    if (run && commit && nv_q[LOCK_BIT]) nv_q <= stage & ~LOCK_M;

  always_ff @(posedge clk)
    if (!por_n) act_q <= nv_q;

  always_ff @(posedge clk) begin
    if (!run) begin
      clr_q <= '0;
      err_q <= 1'b0;
      ok_q  <= 1'b0;
      bad_q <= 1'b0;
    end else begin
      if (wr_en && wr_ok) clr_q <= ~wr_data;
      if (wr_en && !wr_ok) err_q <= 1'b1;
      ok_q  <= key_valid && match;
      bad_q <= key_valid && !match;
    end
  end

  assign rd_data       = act_q;
  assign commit_err    = err_q;
  assign dbg_en        = act_q[DBG_ON_BIT] && !act_q[DBG_OFF_BIT];
  assign fixed_key_sel = act_q[KEYSEL_BIT];
  assign key_ok        = ok_q;
  assign key_bad       = bad_q;

  // R3
  act_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    $past(por_n) |-> $stable(act_q));

  // R2
  stage_clear_only_chk: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    run |=> ((stage & ~$past(stage)) == '0));

  // R5
  lock_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    !nv_q[LOCK_BIT] |=> $stable(nv_q));

  // R2
  rsv_keep_chk: assert property (@(posedge clk) disable iff (!por_n)
    (nv_q & RSV_MASK) == RSV_MASK);

  // R7
  one_pulse_chk: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    !(key_ok && key_bad));
endmodule

// File: tb/sim_cfgword_otp.sv
module sim_cfgword_otp;
  logic clk = 0, por_n = 0, sys_rst_n = 1, wr_en = 0, commit = 0, key_valid = 0;
  logic [31:0] wr_data = '0;
  logic [15:0] key_in = '0, user_key = 16'h1234;
  logic [31:0] rd_data;
  logic commit_err, dbg_en, fixed_key_sel, key_ok, key_bad;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  cfgword_otp u0 (.clk, .por_n, .sys_rst_n, .wr_en, .wr_data, .commit, .rd_data,
    .commit_err, .dbg_en, .fixed_key_sel, .key_valid, .key_in, .user_key,
    .key_ok, .key_bad);

  // {key, user_key, ok when bit4=1, ok when bit4=0}
  localparam logic [33:0] KV [6] = '{
    {16'hA442, 16'h1234, 1'b1, 1'b0},
    {16'hA443, 16'h1234, 1'b0, 1'b0},
    {16'h0000, 16'h1234, 1'b0, 1'b0},
    {16'h1234, 16'h1234, 1'b0, 1'b1},
    {16'h1235, 16'h1234, 1'b0, 1'b0},
    {16'hA442, 16'hA442, 1'b1, 1'b0}
  };

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", r, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic do_por();
    por_n = 0; tick(); tick(); por_n = 1; tick();
  endtask

  task automatic do_sys();
    sys_rst_n = 0; tick(); sys_rst_n = 1; tick();
  endtask

  task automatic do_wr(input logic [31:0] d);
    wr_data = d; wr_en = 1; tick(); wr_en = 0; tick();
  endtask

  task automatic do_commit();
    commit = 1; tick(); commit = 0; tick();
  endtask

  task automatic run_keys(input bit user_mode);
    foreach (KV[i]) begin
      user_key = KV[i][17:2];
      key_in = KV[i][33:18];
      key_valid = 1; tick(); key_valid = 0;
      chk(user_mode ? "R8 key_ok" : "R7 key_ok", 32'(key_ok), 32'(user_mode ? KV[i][0] : KV[i][1]));
      chk(user_mode ? "R8 key_bad" : "R7 key_bad", 32'(key_bad), 32'(user_mode ? !KV[i][0] : !KV[i][1]));
      tick();
      chk("R7 pulse one cycle", 32'({key_ok, key_bad}), 32'd0);
    end
    user_key = 16'h1234;
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick(); do_por();
    chk("R1 rd_data", rd_data, 32'hFFFF_FFFE);
    chk("R1 commit_err", 32'(commit_err), 32'd0);
    chk("R6 dbg_en factory", 32'(dbg_en), 32'd1);
    chk("R7 fixed_key_sel", 32'(fixed_key_sel), 32'd1);
    run_keys(1'b0);

    do_wr(32'hFFFF_FFFA);
    chk("R2 reserved clear rejected", 32'(commit_err), 32'd1);
    do_sys();
    chk("R4 err cleared", 32'(commit_err), 32'd0);
    chk("R4 rd kept", rd_data, 32'hFFFF_FFFE);

    do_wr(32'hFFFF_FEEC);
    chk("R2 legal write no err", 32'(commit_err), 32'd0);
    chk("R3 rd unchanged by write", rd_data, 32'hFFFF_FFFE);
    do_wr(32'hFFFF_FFFE);
    chk("R2 set attempt flagged", 32'(commit_err), 32'd1);
    do_commit();
    chk("R3 rd unchanged by commit", rd_data, 32'hFFFF_FFFE);
    chk("R2 err sticky", 32'(commit_err), 32'd1);
    do_sys();
    chk("R4 rd kept after commit", rd_data, 32'hFFFF_FFFE);
    do_por();
    chk("R3 committed value visible", rd_data, 32'h7FFF_FEEC);
    chk("R6 dbg_en off", 32'(dbg_en), 32'd0);
    chk("R8 fixed_key_sel", 32'(fixed_key_sel), 32'd0);
    run_keys(1'b1);

    do_wr(32'h7FFF_FCEC);
    do_commit();
    do_por();
    chk("R5 locked commit ignored", rd_data, 32'h7FFF_FEEC);
    do_sys();
    chk("R4 rd after sys reset", rd_data, 32'h7FFF_FEEC);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule